// File: doc/BRIEF.md
# Unique Identifier Readout Peripheral

This block is a small register-mapped peripheral that holds a 128-bit per-board identifier and lets software read any four consecutive bytes of it. The identifier arrives on an input port and is held outside the block's resettable state. Software starts a fetch by writing one control word. That word carries a byte index in its upper half, a write flag and an operation pattern. When the word qualifies, the block packs the four addressed identifier bytes into a key register, least significant byte first. Software then reads the key register.

The register bus is a plain 32-bit one with a byte address, a write enable with write data, and a read enable with read data. The window covers 1 KiB. Only two offsets in it are decoded. Reset is synchronous and active high.

Top module: `uid_readout`

## Requirements
- R1: The control register sits at byte offset 0x40 and the key register at 0x60 of a 10-bit byte address. While `rd_en_i` is high, `rd_data_o` returns the current value of the addressed register in the same cycle. While `rd_en_i` is low, `rd_data_o` is 0.
- R2: A write to the control offset stores the full write word with bit 1 forced to 0. A readback of the control register therefore never shows bit 1 set.
- R3: A control write starts a fetch only when bit 1 of the word is set and at least one bit of the word under mask 0xAC00 is set. Bit 1 alone starts nothing, and the pattern alone starts nothing.
- R4: On a fetch, the index is word bits [31:16]. Identifier byte i is `uid_i[8*i+7:8*i]`. When the index is below 16, the key register bits [8*k+7:8*k] take identifier byte index+k, for k = 0 to 3.
- R5: In a fetch whose index is valid, any byte position index+k above 15 loads 0 into its key byte. The position does not wrap.
- R6: The key register keeps its value when a fetch index is 16 or larger, and on any control write that does not meet R3.
- R7: Writes to the key offset are ignored. Any other offset reads as 0 and ignores writes. This includes addresses whose two low bits are not zero, since only full-word accesses are decoded.
- R8: Reset clears the control and key registers to 0. The identifier is not part of the reset state, so the first fetch after reset returns the bytes currently on `uid_i`.
- R9: The key register changes on the clock edge that accepts the qualifying control write. A read in the following cycle returns the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 10 | Byte address within the register window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid in the cycle of rd_en_i |
| uid_i | input | 128 | Identifier bytes, byte 0 in bits [7:0] |

## Verification
A write takes effect at the rising edge where the write strobe is sampled. Reads are combinational, so a result is due in the same cycle as its read strobe. The bench drives each write from a falling edge and releases it at the next falling edge, so exactly one rising edge captures it. It then issues the read in the very next cycle and samples one time unit after driving, well away from any rising edge. This placement confirms that the key appears within one edge of the write and never later. Checks that a register was left untouched read it back in the same way right after the ignored stimulus.

// File: rtl/uid_pkg.sv
package uid_pkg;
    localparam int unsigned REG_W       = 32;
    localparam int unsigned WIN_AW      = 10;
    localparam int unsigned WFLAG_BIT   = 1;
    localparam logic [REG_W-1:0] OP_MASK = 32'h0000_AC00;
    localparam int unsigned IDX_LSB     = 16;
    localparam int unsigned IDX_W       = 16;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] key;
    } uid_regs_t;
endpackage

// File: rtl/uid_regdec.sv
module uid_regdec #(
    parameter int unsigned AW       = 10,
    parameter int unsigned CTRL_OFF = 'h40,
    parameter int unsigned KEY_OFF  = 'h60
) (
    input  logic [AW-1:0] addr_i,
    output logic          sel_ctrl_o,
    output logic          sel_key_o
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFF);
    localparam logic [AW-1:0] KEY_A  = AW'(KEY_OFF);

    logic aligned;

    always_comb begin
        aligned    = (addr_i[1:0] == 2'b00);
        sel_ctrl_o = aligned && (addr_i == CTRL_A);
        sel_key_o  = aligned && (addr_i == KEY_A);
    end
endmodule

// File: rtl/uid_key_gather.sv
module uid_key_gather #(
    parameter int unsigned ID_BYTES = 16,
    parameter int unsigned KEY_BYTES = 4,
    parameter int unsigned IDX_W = 16
) (
    input  logic [8*ID_BYTES-1:0]  uid_i,
    input  logic [IDX_W-1:0]       idx_i,
    output logic                   idx_ok_o,
    output logic [8*KEY_BYTES-1:0] key_o
);
    localparam int unsigned SEL_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam int unsigned POS_W = IDX_W + 1;

    assign idx_ok_o = ({1'b0, idx_i} < POS_W'(ID_BYTES));

    for (genvar k = 0; k < KEY_BYTES; k++) begin : g_lane
        logic [POS_W-1:0] pos;
        logic             in_range;
        logic [SEL_W-1:0] sel;
        always_comb begin
            pos      = {1'b0, idx_i} + POS_W'(k);
            in_range = (pos < POS_W'(ID_BYTES));
            sel      = pos[SEL_W-1:0];
            key_o[8*k +: 8] = in_range ? uid_i[{sel, 3'b000} +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/uid_readout.sv
module uid_readout
    import uid_pkg::*;
#(
    parameter int unsigned ID_BYTES = 16,
    parameter int unsigned CTRL_OFF = 'h40,
    parameter int unsigned KEY_OFF  = 'h60
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIN_AW-1:0]     addr_i,
    input  logic                  wr_en_i,
    input  logic [REG_W-1:0]      wr_data_i,
    input  logic                  rd_en_i,
    output logic [REG_W-1:0]      rd_data_o,
    input  logic [8*ID_BYTES-1:0] uid_i
);
    localparam int unsigned KEY_BYTES = REG_W / 8;

    uid_regs_t regs_d, regs_q;

    logic             sel_ctrl, sel_key;
    logic             idx_ok;
    logic [REG_W-1:0] gathered;
    logic             trig;

    uid_regdec #(
        .AW       (WIN_AW),
        .CTRL_OFF (CTRL_OFF),
        .KEY_OFF  (KEY_OFF)
    ) u_dec (
        .addr_i     (addr_i),
        .sel_ctrl_o (sel_ctrl),
        .sel_key_o  (sel_key)
    );

    uid_key_gather #(
        .ID_BYTES  (ID_BYTES),
        .KEY_BYTES (KEY_BYTES),
        .IDX_W     (IDX_W)
    ) u_gather (
        .uid_i    (uid_i),
        .idx_i    (wr_data_i[IDX_LSB +: IDX_W]),
        .idx_ok_o (idx_ok),
        .key_o    (gathered)
    );

    always_comb begin
        regs_d = regs_q;
        trig   = wr_data_i[WFLAG_BIT] && ((wr_data_i & OP_MASK) != '0);
        if (wr_en_i && sel_ctrl) begin
            regs_d.ctrl = wr_data_i;
            regs_d.ctrl[WFLAG_BIT] = 1'b0;
            if (trig && idx_ok) begin
                regs_d.key = gathered;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            if (sel_ctrl) begin
                rd_data_o = regs_q.ctrl;
            end else if (sel_key) begin
                rd_data_o = regs_q.key;
            end
        end
    end

    // R2: the flag bit never appears on a control readback
    p_flag_hidden_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && sel_ctrl) |-> (rd_data_o[WFLAG_BIT] == 1'b0));

    // R6: without a qualifying control write the key holds
    p_key_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && sel_ctrl && wr_data_i[WFLAG_BIT] && ((wr_data_i & OP_MASK) != '0))
        |=> $stable(regs_q.key));

    // R7: writes that miss the control offset leave the control register alone
    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && sel_ctrl) |=> $stable(regs_q.ctrl));

    // R8: one cycle after reset both registers read as zero
    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> (regs_q.ctrl == '0 && regs_q.key == '0));

    // R1: idle read bus is zero
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |-> (rd_data_o == '0));

    // R5: a lane past the end of the identifier loads zero
    p_tail_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel_ctrl && idx_ok && wr_data_i[WFLAG_BIT]
         && ((wr_data_i & OP_MASK) != '0)
         && (wr_data_i[IDX_LSB +: IDX_W] == 16'(ID_BYTES - 1)))
        |=> (regs_q.key[REG_W-1:8] == '0));
endmodule

// File: tb/uid_readout_tb.sv
module uid_readout_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic [9:0]   addr_i;
    logic         wr_en_i;
    logic [31:0]  wr_data_i;
    logic         rd_en_i;
    logic [31:0]  rd_data_o;
    logic [127:0] uid_i;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [127:0] UID_A = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    localparam logic [127:0] UID_B = 128'h11223344_55667788_99aabbcc_ddeeff00;

    always #10 clk = ~clk;

    uid_readout u_dut (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .uid_i     (uid_i)
    );

    function automatic logic [31:0] exp_key(input logic [127:0] u, input int idx);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            if (idx + k < 16) r[8*k +: 8] = u[8*(idx+k) +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        addr_i = a; rd_en_i = 1'b1;
        #1 d = rd_data_o;
        rd_en_i = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(10'h40, v); check("R8 ctrl after reset", v, 32'h0);
        rd(10'h60, v); check("R8 key after reset", v, 32'h0);
        addr_i = 10'h40; rd_en_i = 1'b0; #1;
        check("R1 idle read bus", rd_data_o, 32'h0);
    endtask

    task automatic t_fetch_basic;
        logic [31:0] v;
        wr(10'h40, 32'h0000_AC02);
        rd(10'h60, v); check("R4 R9 key idx 0", v, exp_key(UID_A, 0));
        rd(10'h40, v); check("R2 ctrl readback", v, 32'h0000_AC00);
        wr(10'h40, 32'h0005_0802);
        rd(10'h60, v); check("R3 R4 key idx 5 single op bit", v, exp_key(UID_A, 5));
        wr(10'h40, 32'h000C_2002);
        rd(10'h60, v); check("R4 key idx 12", v, exp_key(UID_A, 12));
    endtask

    task automatic t_tail;
        logic [31:0] v;
        wr(10'h40, 32'h000E_8002);
        rd(10'h60, v); check("R5 key idx 14", v, {16'h0, UID_A[127:112]});
        wr(10'h40, 32'h000F_0402);
        rd(10'h60, v); check("R5 key idx 15", v, {24'h0, UID_A[127:120]});
    endtask

    task automatic t_no_trigger;
        logic [31:0] v;
        wr(10'h40, 32'h0001_AC02);
        wr(10'h40, 32'h0003_0002);
        rd(10'h60, v); check("R3 flag without pattern", v, exp_key(UID_A, 1));
        rd(10'h40, v); check("R2 ctrl stored", v, 32'h0003_0000);
        wr(10'h40, 32'h0002_AC00);
        rd(10'h60, v); check("R3 pattern without flag", v, exp_key(UID_A, 1));
        wr(10'h40, 32'h0004_53FF);
        rd(10'h60, v); check("R3 bits outside pattern", v, exp_key(UID_A, 1));
        rd(10'h40, v); check("R2 ctrl flag cleared", v, 32'h0004_53FD);
    endtask

    task automatic t_bad_index;
        logic [31:0] v;
        wr(10'h40, 32'h0010_AC02);
        rd(10'h60, v); check("R6 index 16 holds key", v, exp_key(UID_A, 1));
        rd(10'h40, v); check("R2 ctrl idx 16", v, 32'h0010_AC00);
        wr(10'h40, 32'hFFFF_AC02);
        rd(10'h60, v); check("R6 index max holds key", v, exp_key(UID_A, 1));
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        wr(10'h60, 32'hDEAD_BEEF);
        rd(10'h60, v); check("R7 key write ignored", v, exp_key(UID_A, 1));
        wr(10'h44, 32'h0000_AC02);
        rd(10'h40, v); check("R7 other write leaves ctrl", v, 32'hFFFF_AC00);
        rd(10'h60, v); check("R7 other write leaves key", v, exp_key(UID_A, 1));
        rd(10'h44, v); check("R7 other read zero", v, 32'h0);
        rd(10'h41, v); check("R7 misaligned read zero", v, 32'h0);
        wr(10'h42, 32'h0006_AC02);
        rd(10'h60, v); check("R7 misaligned write ignored", v, exp_key(UID_A, 1));
        rd(10'h240, v); check("R1 ctrl alias absent", v, 32'h0);
    endtask

    task automatic t_reset_uid;
        logic [31:0] v;
        uid_i = UID_B;
        rd(10'h60, v); check("R6 uid change alone keeps key", v, exp_key(UID_A, 1));
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(10'h60, v); check("R8 key cleared mid run", v, 32'h0);
        rd(10'h40, v); check("R8 ctrl cleared mid run", v, 32'h0);
        wr(10'h40, 32'h0007_AC02);
        rd(10'h60, v); check("R8 R4 fetch after reset", v, exp_key(UID_B, 7));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr_i = '0; wr_en_i = 1'b0; wr_data_i = '0; rd_en_i = 1'b0;
        uid_i = UID_A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fetch_basic();
        t_tail();
        t_no_trigger();
        t_bad_index();
        t_ignored();
        t_reset_uid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule